// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a 32-bit-wide synchronous SRAM. It has registered inputs, a registered read path, and a two-bit wraparound burst counter. Control, address and write data are captured on the rising clock edge.

An access starts in one of two ways:
- A processor-side strobe starts an access that is always a read.
- A controller-side strobe starts an access that can write in the same cycle.

While the device stays selected and no strobe is given, an advance input steps the low two address bits through a four-beat linear or interleaved sequence. Byte lanes are written selectively or all at once.

Read data leaves through an output register together with a drive flag meant for an external tri-state buffer. Data in and data out are separate ports. A sleep request blanks the device: after a short synchronizer delay it ignores all accesses, and the array contents are kept.

A memory controller uses the block as a cache or buffer store. It issues a base address with one strobe, then streams further beats with the advance input.

Top module: `pipe_burst_sram`

## Requirements
- R1: An access starts at an edge when an accepted strobe is low and `chipEn1N`=0, `chipEn2`=1, `chipEn3N`=0. An accepted strobe seen with any of the three enables inactive deselects the device. While deselected, edges without a strobe neither read nor write.
- R2: `procStrobeN` is disregarded while `chipEn1N` is high, and that edge is handled as if no strobe were present. When both strobes are low, only the processor strobe takes effect.
- R3: An access started by `procStrobeN` is a read, and the write controls on that edge have no effect. A write to that address happens on the next edge, using the write controls sampled there (with `advanceN` high).
- R4: An access started by `ctrlStrobeN` (with the processor strobe not taking effect) writes on that same edge when the write controls are active. `advanceN` is ignored on a start edge.
- R5: `globalWrN`=0 writes all four bytes. Otherwise, with `byteWrEnN`=0, byte b (`wrData[8b+7:8b]`) is written exactly when `byteSelN[b]`=0, for any mix of lanes. With `byteWrEnN`=1 and `globalWrN`=1, nothing is written.
- R6: Read data addressed at edge k is on `rdData` after edge k+1. `rdDrive` is 1 only while `outEnN` is 0, and it follows `outEnN` without a clock. For a read started from the deselected state, that first output cycle has `rdDrive`=0.
- R7: After any edge that performs a write or a deselect, `rdDrive` is 0.
- R8: With no strobe while selected, `advanceN`=0 moves to the next burst address and `advanceN`=1 stays on the current one. Either kind of edge reads, or writes when the write controls are active.
- R9: Beat i of a burst with base low bits s uses low bits (s+i) mod 4 when `linearBurst`=1 and s XOR i when `linearBurst`=0. The sequence wraps after four beats; the upper address bits stay fixed.
- R10: Let `sleepReq` be high before edge e0. Edges from e2 onward then ignore all inputs, and `rdDrive` is 0 from e1 on. Let `sleepReq` fall before edge f0. Edges f0, f1 and f2 are still ignored, and f3 is accepted. The device wakes deselected, with memory intact.
- R11: Synchronous active-low `rstN` clears `rdDrive`, the selection and the sleep state. The memory array keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipEn1N | input | 1 | Chip enable, active low; also gates the processor strobe |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| byteSelN | input | 4 | Per-lane write selects, active low |
| byteWrEnN | input | 1 | Byte write enable, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Sleep request, active high |
| linearBurst | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| rdDrive | output | 1 | Output-drive flag for an external tri-state buffer |

## Verification
Writes land in the array on the edge that carries them. A read shows on `rdData` one edge after its address edge. The drive flag drops on the very edge of a write or deselect, and it tracks `outEnN` with no clock. Sleep takes effect on the third edge after the request and releases on the fourth edge after it falls.

The bench drives inputs one time unit after a rising edge and samples one time unit after the following edge. Each expected value is indexed by that exact edge count. For example, a burst beat j is checked against the address issued at edge j-1, and a read-back is judged on the third edge after its strobe, so the first-cycle mask never confuses the data check. The asynchronous output-enable path is checked between edges, without a clock.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 4;
  localparam int DATA_W    = BYTE_W * NUM_BYTES;

  typedef struct packed {
    logic                 memWr;     // write the lanes in byteMask this edge
    logic [NUM_BYTES-1:0] byteMask;  // lanes to update
    logic                 outLoad;   // load output register from read address
    logic                 driveNext; // drive flag value after this edge
    logic                 quiet;     // sleep window: force output off
  } dpStrobes_t;
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic              byteWrEnN,
  input  logic              globalWrN,
  input  logic              sleepReq,
  input  logic              linearBurst,
  input  logic [ADDR_W-1:0] addr,
  output dpStrobes_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int HI_W = ADDR_W - 2;

  // sleep synchronizer and state flag
  logic syncA, syncB, sleepFlag, blocked;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0; syncB <= 1'b0; sleepFlag <= 1'b0;
    end else begin
      syncA <= sleepReq; syncB <= syncA; sleepFlag <= syncB;
    end
  end
  assign blocked = syncB | sleepFlag;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] step,
                                          input logic       lin);
    return lin ? (base + step) : (base ^ step);
  endfunction

  logic            selected;
  logic [HI_W-1:0] hiReg;
  logic [1:0]      baseLow, burstCnt, nextCnt, curLow, effLow;
  logic            s1Read, s1First;
  logic [ADDR_W-1:0] s1Addr, effAddr;

  logic procHit, strobeAny, chipOn, wrReq;
  logic startAcc, deselect, contAcc, stepNow;
  logic isWrite, isRead, kill;
  logic [NUM_BYTES-1:0] wrMask;

  always_comb begin
    procHit   = !procStrobeN && !chipEn1N;
    strobeAny = procHit || !ctrlStrobeN;
    chipOn    = !chipEn1N && chipEn2 && !chipEn3N;
    if (!globalWrN)      wrMask = '1;
    else if (!byteWrEnN) wrMask = ~byteSelN;
    else                 wrMask = '0;
    wrReq     = |wrMask;
    startAcc  = !blocked && strobeAny && chipOn;
    deselect  = !blocked && strobeAny && !chipOn;
    contAcc   = !blocked && !strobeAny && selected;
    stepNow   = contAcc && !advanceN;
    nextCnt   = burstCnt + 2'd1;
    curLow    = burstLow(baseLow, burstCnt, linearBurst);
    if (startAcc)     effLow = addr[1:0];
    else if (stepNow) effLow = burstLow(baseLow, nextCnt, linearBurst);
    else              effLow = curLow;
    effAddr   = startAcc ? addr : {hiReg, effLow};
    isWrite   = wrReq && ((startAcc && !procHit) || contAcc);
    isRead    = (startAcc || contAcc) && !isWrite;
    kill      = deselect || isWrite || blocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selected <= 1'b0;
      hiReg    <= '0;
      baseLow  <= '0;
      burstCnt <= '0;
      s1Read   <= 1'b0;
      s1First  <= 1'b0;
      s1Addr   <= '0;
    end else begin
      if (startAcc) begin
        selected <= 1'b1;
        hiReg    <= addr[ADDR_W-1:2];
        baseLow  <= addr[1:0];
        burstCnt <= '0;
      end else if (deselect || blocked) begin
        selected <= 1'b0;
      end else if (stepNow) begin
        burstCnt <= nextCnt;
      end
      s1Read  <= isRead;
      s1First <= startAcc && !selected;
      s1Addr  <= effAddr;
    end
  end

  always_comb begin
    strb.memWr     = isWrite;
    strb.byteMask  = wrMask;
    strb.outLoad   = s1Read;
    strb.driveNext = s1Read && !s1First && !kill;
    strb.quiet     = blocked;
  end
  assign wrAddr = effAddr;
  assign rdAddr = s1Addr;

  // R1: a deselecting strobe leaves the device unselected
  assert_deselect_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    deselect |=> !selected);
  // R2: both strobes low with CE1 low never writes
  assert_proc_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ctrlStrobeN && !chipEn1N) |-> !strb.memWr);
  // R3: a processor-started access is a read
  assert_proc_reads_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && procHit) |-> !strb.memWr);
  // R5: a write always touches at least one lane
  assert_mask_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWr |-> (strb.byteMask != '0));
  // R6: a read from the deselected state is not driven on its first output cycle
  assert_first_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startAcc && !selected) |=> !strb.driveNext);
  // R8: an advance step moves the burst counter by one
  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    stepNow |=> (burstCnt == $past(burstCnt) + 2'd1));
  // R10: nothing is written during the sleep window
  assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> !strb.memWr);
endmodule

// File: rtl/pbs_datapath.sv
module pbs_datapath
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : gLane
      logic [BYTE_W-1:0] laneMem [DEPTH];
      logic [BYTE_W-1:0] laneOut;
      always_ff @(posedge clk) begin
        if (strb.memWr && strb.byteMask[b])
          laneMem[wrAddr] <= wrData[b*BYTE_W +: BYTE_W];
      end
      always_ff @(posedge clk) begin
        if (!rstN)             laneOut <= '0;
        else if (strb.outLoad) laneOut <= laneMem[rdAddr];
      end
      assign rdData[b*BYTE_W +: BYTE_W] = laneOut;
    end
  endgenerate

  logic driveReg;
  always_ff @(posedge clk) begin
    if (!rstN) driveReg <= 1'b0;
    else       driveReg <= strb.driveNext;
  end
  assign rdDrive = driveReg && !outEnN && !strb.quiet;

  // R7: a write edge leaves the output undriven
  assert_write_silences_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWr |=> !driveReg);
  // R6: the drive flag is never raised without a pending read
  assert_drive_needs_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.outLoad |=> !driveReg);
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter  int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 procStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advanceN,
  input  logic                 chipEn1N,
  input  logic                 chipEn2,
  input  logic                 chipEn3N,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 byteWrEnN,
  input  logic                 globalWrN,
  input  logic                 outEnN,
  input  logic                 sleepReq,
  input  logic                 linearBurst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdDrive
);
  dpStrobes_t        strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  pbs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .byteSelN(byteSelN), .byteWrEnN(byteWrEnN), .globalWrN(globalWrN),
    .sleepReq(sleepReq), .linearBurst(linearBurst), .addr(addr),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  pbs_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;
  logic clk = 1'b0;
  logic rstN, procN, ctrlN, advN, ce1N, ce2, ce3N, bweN, gwN, oeN, sleepReq, linearBurst;
  logic [3:0]  bselN;
  logic [7:0]  addr;
  logic [31:0] wrData, rdData;
  logic        rdDrive;
  logic [31:0] refMem [256];
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pipe_burst_sram uut (
    .clk(clk), .rstN(rstN), .procStrobeN(procN), .ctrlStrobeN(ctrlN), .advanceN(advN),
    .chipEn1N(ce1N), .chipEn2(ce2), .chipEn3N(ce3N), .byteSelN(bselN),
    .byteWrEnN(bweN), .globalWrN(gwN), .outEnN(oeN), .sleepReq(sleepReq),
    .linearBurst(linearBurst), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdDrive(rdDrive)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setIdle();
    procN = 1; ctrlN = 1; advN = 1; ce1N = 0; ce2 = 1; ce3N = 0;
    bselN = 4'hF; bweN = 1; gwN = 1; wrData = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] pat(int a);
    return 32'h9E3779B9 * (a + 1);
  endfunction

  function automatic int order(int s, int i, bit lin);
    return lin ? ((s + i) & 3) : ((s ^ i) & 3);
  endfunction

  task automatic ctrlWriteAll(int a, logic [31:0] d);
    setIdle(); ctrlN = 0; addr = 8'(a); gwN = 0; wrData = d;
    step(); refMem[a] = d; setIdle();
  endtask

  // strobe, then two suspend edges; third edge shows a driven re-read of a
  task automatic readCheck(int a, string req);
    setIdle(); ctrlN = 0; addr = 8'(a); step();
    setIdle(); step(); step();
    check({req, " drive"}, {31'd0, rdDrive}, 32'd1);
    check({req, " data"}, rdData, refMem[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    foreach (refMem[i]) refMem[i] = '0;
    setIdle(); oeN = 0; sleepReq = 0; linearBurst = 1; addr = '0; rstN = 0;
    repeat (3) step();
    check("R11 reset drive", {31'd0, rdDrive}, 32'd0);
    rstN = 1;

    // R6: first read out of deselect is masked, the next cycle drives
    setIdle(); ctrlN = 0; addr = 8'd0; step();
    setIdle(); step();
    check("R6 first cycle masked", {31'd0, rdDrive}, 32'd0);
    step();
    check("R6 second cycle drives", {31'd0, rdDrive}, 32'd1);
    oeN = 1; #1;
    check("R6 async outEn off", {31'd0, rdDrive}, 32'd0);
    oeN = 0; #1;
    check("R6 async outEn on", {31'd0, rdDrive}, 32'd1);

    // fill with global writes; R7 after a write edge
    for (int a = 0; a < 128; a++) begin
      ctrlWriteAll(a, pat(a));
      if (a == 0) check("R7 write drops drive", {31'd0, rdDrive}, 32'd0);
    end

    // R5: every byte-select combination
    for (int m = 0; m < 16; m++) begin
      setIdle(); ctrlN = 0; addr = 8'(16 + m); bweN = 0; bselN = ~4'(m);
      d = 32'hC0DE5A00 ^ (32'(m) * 32'h01030507);
      wrData = d; step();
      for (int b = 0; b < 4; b++)
        if (m[b]) refMem[16 + m][b*8 +: 8] = d[b*8 +: 8];
    end
    setIdle(); ctrlN = 0; addr = 8'd32; bweN = 1; bselN = 4'h0; wrData = 32'h12345678; step();
    setIdle(); ctrlN = 0; addr = 8'd33; gwN = 0; bselN = 4'hF; wrData = 32'hFEEDF00D; step();
    refMem[33] = 32'hFEEDF00D;
    for (int a = 16; a < 34; a++) readCheck(a, "R5 byte lanes");

    // R3: processor strobe reads, write lands on the following edge
    setIdle(); procN = 0; addr = 8'd40; gwN = 0; wrData = 32'hDEAD0001; step();
    setIdle(); gwN = 0; wrData = 32'hBEEF0040; step();
    refMem[40] = 32'hBEEF0040;
    readCheck(40, "R3 write next edge");
    setIdle(); procN = 0; addr = 8'd42; gwN = 0; wrData = 32'hDEAD0042; step();
    setIdle(); step();
    readCheck(42, "R3 start edge no write");
    // R2: both strobes low -> processor wins, no write
    setIdle(); procN = 0; ctrlN = 0; addr = 8'd41; gwN = 0; wrData = 32'hDEAD0041; step();
    setIdle(); step();
    readCheck(41, "R2 priority no write");
    // R4: controller write ignores advance on its start edge
    setIdle(); ctrlN = 0; advN = 0; addr = 8'd44; gwN = 0; wrData = 32'hAB440044; step();
    refMem[44] = 32'hAB440044;
    readCheck(44, "R4 same-edge write");
    readCheck(45, "R4 neighbour untouched");

    // R2: processor strobe with CE1 high acts as no strobe (suspend, not deselect)
    readCheck(50, "R2 setup");
    setIdle(); procN = 0; ce1N = 1; addr = 8'd60; step();
    setIdle(); step();
    check("R2 ce1 high keeps drive", {31'd0, rdDrive}, 32'd1);
    check("R2 ce1 high keeps addr", rdData, refMem[50]);

    // R1/R7: deselect
    setIdle(); ctrlN = 0; ce2 = 0; addr = 8'd50; step();
    check("R7 deselect drops drive", {31'd0, rdDrive}, 32'd0);
    setIdle(); gwN = 0; addr = 8'd50; wrData = 32'h0BAD0050; step();
    setIdle(); ctrlN = 0; ce3N = 1; gwN = 0; addr = 8'd51; wrData = 32'h0BAD0051; step();
    readCheck(50, "R1 no write while deselected");
    readCheck(51, "R1 disabled chip no write");

    // R8/R9: read bursts, both orders, every start offset
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        setIdle(); linearBurst = lin[0]; ctrlN = 0; addr = 8'(64 + s); step();
        for (int j = 1; j <= 6; j++) begin
          setIdle(); advN = (j <= 4) ? 1'b0 : 1'b1; step();
          check(lin ? "R9 linear beat" : "R9 interleave beat",
                rdData, refMem[64 + order(s, (j - 1 > 4) ? 4 : j - 1, lin[0])]);
          check("R8 burst drive", {31'd0, rdDrive}, 32'd1);
        end
      end
    end

    // R8: write bursts with continue and suspend
    linearBurst = 1;
    setIdle(); ctrlN = 0; addr = 8'd82; gwN = 0; wrData = 32'hB0000082; step(); refMem[82] = 32'hB0000082;
    setIdle(); advN = 0; gwN = 0; wrData = 32'hB1000083; step(); refMem[83] = 32'hB1000083;
    setIdle(); advN = 1; gwN = 0; wrData = 32'hB2000083; step(); refMem[83] = 32'hB2000083;
    setIdle(); advN = 0; gwN = 0; wrData = 32'hB3000080; step(); refMem[80] = 32'hB3000080;
    for (int a = 80; a < 84; a++) readCheck(a, "R8 linear write burst");
    linearBurst = 0;
    setIdle(); ctrlN = 0; addr = 8'd85; gwN = 0; wrData = 32'hC0000085; step(); refMem[85] = 32'hC0000085;
    setIdle(); advN = 0; gwN = 0; wrData = 32'hC1000084; step(); refMem[84] = 32'hC1000084;
    setIdle(); advN = 0; gwN = 0; wrData = 32'hC2000087; step(); refMem[87] = 32'hC2000087;
    for (int a = 84; a < 88; a++) readCheck(a, "R9 interleave write burst");

    // R10: sleep entry, blocked window, exit
    readCheck(90, "R10 setup");
    setIdle(); sleepReq = 1; step(); step();
    check("R10 drive off in sleep", {31'd0, rdDrive}, 32'd0);
    setIdle(); ctrlN = 0; gwN = 0; addr = 8'd90; wrData = 32'h5EE90090; step();
    setIdle(); ctrlN = 0; gwN = 0; addr = 8'd91; wrData = 32'h5EE90091; step();
    check("R10 drive stays off", {31'd0, rdDrive}, 32'd0);
    sleepReq = 0;
    setIdle(); ctrlN = 0; gwN = 0; addr = 8'd92; wrData = 32'h5EE90092; step();
    setIdle(); ctrlN = 0; gwN = 0; addr = 8'd93; wrData = 32'h5EE90093; step();
    setIdle(); ctrlN = 0; gwN = 0; addr = 8'd94; wrData = 32'h5EE90094; step();
    setIdle(); ctrlN = 0; gwN = 0; addr = 8'd95; wrData = 32'h5EE90095; step();
    refMem[95] = 32'h5EE90095;
    for (int a = 90; a < 96; a++) readCheck(a, "R10 sleep window");

    // R11: reset mid-run keeps memory
    rstN = 0; step(); step();
    check("R11 reset drive mid-run", {31'd0, rdDrive}, 32'd0);
    rstN = 1;
    readCheck(33, "R11 memory kept");
    readCheck(100, "R11 memory kept");

    done = 1;
    summary();
    $finish;
  end
endmodule